// File: doc/BRIEF.md
# Character LCD Nibble Bridge

This block sits on a simple 32-bit register bus and turns processor accesses into cycles on the 4-bit parallel bus of a character LCD module. A write to the command word or to the data word becomes a single nibble transfer. The nibble is taken from bits 7:4 of the written value. Register-select is low for the command word and high for the data word. A read of the command word starts a nibble read with register-select low, which fetches the busy flag and the address counter from the module.

A full byte is read from the module in two nibble reads. Reading the command word fetches the upper nibble. The block captures it and raises a raw valid flag. It also raises an interrupt if that interrupt is enabled. Software then reads the read-data word. That read returns the captured nibble and starts the second nibble read. The second capture sets only the raw valid flag, so software must poll for it. Writing a word with bit 8 clear to the raw word clears the flag and the pending interrupt.

Every LCD cycle runs through a setup phase, an enable-high phase and a hold phase. The length of each phase is a parameter in clock cycles. While a cycle is running, the block reports busy. Any access that would start another cycle during that time is dropped.

Top module: `lcd_nib_bridge`

## Requirements
- R1: After reset, lcd_en, bus_busy and irq are low, and reads of the raw word (word 3) and the mask word (word 4) return zero.
- R2: A write to word 0 (byte offset 0x00) when the block is idle produces exactly one enable pulse. During the cycle lcd_rs=0, lcd_rw=0, lcd_d_oe=1, and lcd_d_out equals bits 7:4 of the written value.
- R3: A write to word 1 (offset 0x04) when the block is idle produces one enable pulse with lcd_rs=1, lcd_rw=0, and lcd_d_out equal to bits 7:4 of the written value.
- R4: Each LCD cycle holds lcd_en low for SETUP_CYC cycles, high for exactly PULSE_CYC cycles, and low for HOLD_CYC cycles. bus_busy is high for all SETUP_CYC+PULSE_CYC+HOLD_CYC cycles, and lcd_rs, lcd_rw and lcd_d_out stay stable throughout.
- R5: An access to word 0 or word 1 made while bus_busy is high is ignored and produces no further enable pulse.
- R6: A read of word 0 when the block is idle starts a read cycle with lcd_rs=0, lcd_rw=1 and lcd_d_oe=0. The nibble on lcd_d_in in the last enable-high cycle is returned in bits 7:4 of word 2 (offset 0x08), and bit 8 of the raw word is set.
- R7: Capturing the first nibble of a pair sets a pending flag. irq and bit 0 of the status word (word 5, 0x14) both equal pending AND mask bit 0, and they stay high until the raw word is written with bit 8 = 0.
- R8: A read of word 2 after a first-nibble capture returns the captured nibble and starts the second nibble read. Its capture sets raw bit 8 but does not set the pending flag.
- R9: With mask bit 0 clear, irq and status bit 0 stay low after a first-nibble capture. Writing mask bit 0 = 1 later raises them.
- R10: A read of word 2 when no pair is open starts no LCD cycle.
- R11: A write to the raw word with bit 8 = 1 leaves the raw flag and the pending flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed word |
| bus_busy | output | 1 | An LCD cycle is in progress |
| irq | output | 1 | Masked first-nibble interrupt |
| lcd_rs | output | 1 | LCD register-select |
| lcd_rw | output | 1 | LCD read/write (1 = read) |
| lcd_en | output | 1 | LCD enable strobe |
| lcd_d_out | output | 4 | Nibble driven to the LCD |
| lcd_d_oe | output | 1 | Output enable for lcd_d_out |
| lcd_d_in | input | 4 | Nibble returned by the LCD |

## Verification
Some properties are checked on every cycle. The enable pulse only appears while the block is busy. Bus signals stay stable for the whole length of a cycle. The data bus is never driven during a read. The interrupt never stands without the raw flag and persists until software clears it.

Other behaviour only shows up in the bench's scenarios. These are:
- the exact phase lengths;
- the dropping of overlapping accesses;
- the first-nibble and second-nibble sequence in which only the first capture raises the interrupt;
- late unmasking;
- the harmless raw write with bit 8 set.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_e;
  localparam logic [2:0] W_CMD  = 3'd0;
  localparam logic [2:0] W_DAT  = 3'd1;
  localparam logic [2:0] W_RD   = 3'd2;
  localparam logic [2:0] W_RAW  = 3'd3;
  localparam logic [2:0] W_MASK = 3'd4;
  localparam logic [2:0] W_STAT = 3'd5;
  localparam int VALID_BIT = 8;
endpackage

// File: rtl/lcdb_phase.sv
module lcdb_phase
  import lcdb_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       st_rs,
  input  logic       st_rw,
  input  logic [3:0] st_nib,
  input  logic [3:0] lcd_d_in,
  output logic       busy,
  output logic       cap,
  output logic [3:0] cap_nib,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [3:0] lcd_d_out,
  output logic       lcd_d_oe
);
  localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAXC   = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  phase_e           ph_q, ph_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rs_q, rw_q;
  logic [3:0]       nib_q;
  logic             ld;

  assign ld = (ph_q == PH_IDLE) && start;

  always_comb begin
    ph_n  = ph_q;
    cnt_n = cnt_q;
    cap   = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_n  = PH_SETUP;
        cnt_n = CNT_W'(SETUP_CYC - 1);
      end
      PH_SETUP: if (cnt_q == '0) begin
        ph_n  = PH_PULSE;
        cnt_n = CNT_W'(PULSE_CYC - 1);
      end else cnt_n = cnt_q - 1'b1;
      PH_PULSE: if (cnt_q == '0) begin
        ph_n  = PH_HOLD;
        cnt_n = CNT_W'(HOLD_CYC - 1);
        cap   = rw_q;
      end else cnt_n = cnt_q - 1'b1;
      PH_HOLD: if (cnt_q == '0) ph_n = PH_IDLE;
               else cnt_n = cnt_q - 1'b1;
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q  <= 1'b0;
      rw_q  <= 1'b0;
      nib_q <= '0;
    end else if (ld) begin
      rs_q  <= st_rs;
      rw_q  <= st_rw;
      nib_q <= st_nib;
    end
  end

  assign busy      = (ph_q != PH_IDLE);
  assign lcd_en    = (ph_q == PH_PULSE);
  assign lcd_rs    = rs_q;
  assign lcd_rw    = rw_q;
  assign lcd_d_out = nib_q;
  assign lcd_d_oe  = busy && !rw_q;
  assign cap_nib   = lcd_d_in;
endmodule

// File: rtl/lcdb_regs.sv
module lcdb_regs
  import lcdb_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          cap,
  input  logic [3:0]    cap_nib,
  output logic          start,
  output logic          st_rs,
  output logic          st_rw,
  output logic [3:0]    st_nib,
  output logic          irq,
  output logic          raw_o
);
  logic [2:0] idx;
  logic       wr_cmd, wr_dat, wr_raw, wr_mask, rd_cmd, rd_rd, clr;
  logic       st_wr, st_rd1, st_rd2;
  logic       mask_q, mask_n, raw_q, raw_n, pend_q, pend_n;
  logic       pair_q, pair_n, sec_q, sec_n;
  logic [3:0] nib_q, nib_n;

  assign idx     = addr[AW-1:2];
  assign wr_cmd  = wr_en && idx == W_CMD;
  assign wr_dat  = wr_en && idx == W_DAT;
  assign wr_raw  = wr_en && idx == W_RAW;
  assign wr_mask = wr_en && idx == W_MASK;
  assign rd_cmd  = rd_en && !wr_en && idx == W_CMD;
  assign rd_rd   = rd_en && !wr_en && idx == W_RD;
  assign clr     = wr_raw && !wdata[VALID_BIT];

  assign st_wr  = !busy && (wr_cmd || wr_dat);
  assign st_rd1 = !busy && rd_cmd;
  assign st_rd2 = !busy && rd_rd && pair_q;
  assign start  = st_wr || st_rd1 || st_rd2;
  assign st_rs  = wr_dat;
  assign st_rw  = !st_wr;
  assign st_nib = wdata[7:4];

  always_comb begin
    mask_n = wr_mask ? wdata[0] : mask_q;
    nib_n  = cap ? cap_nib : nib_q;
    raw_n  = raw_q;
    pend_n = pend_q;
    if (clr) begin
      raw_n  = 1'b0;
      pend_n = 1'b0;
    end
    if (cap) raw_n = 1'b1;
    if (cap && !sec_q) pend_n = 1'b1;
    sec_n  = sec_q;
    pair_n = pair_q;
    if (st_rd1) begin
      sec_n  = 1'b0;
      pair_n = 1'b0;
    end else if (st_rd2) begin
      sec_n  = 1'b1;
      pair_n = 1'b0;
    end
    if (cap && !sec_q) pair_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      raw_q  <= 1'b0;
      pend_q <= 1'b0;
      pair_q <= 1'b0;
      sec_q  <= 1'b0;
      nib_q  <= '0;
    end else begin
      mask_q <= mask_n;
      raw_q  <= raw_n;
      pend_q <= pend_n;
      pair_q <= pair_n;
      sec_q  <= sec_n;
      nib_q  <= nib_n;
    end
  end

  assign irq   = pend_q && mask_q;
  assign raw_o = raw_q;

  always_comb begin
    rdata = '0;
    unique case (idx)
      W_RD:    rdata[7:4]       = nib_q;
      W_RAW:   rdata[VALID_BIT] = raw_q;
      W_MASK:  rdata[0]         = mask_q;
      W_STAT:  rdata[0]         = irq;
      default: rdata            = '0;
    endcase
  end
endmodule

// File: rtl/lcd_nib_bridge.sv
module lcd_nib_bridge #(
  parameter int DW        = 32,
  parameter int AW        = 5,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bus_busy,
  output logic          irq,
  output logic          lcd_rs,
  output logic          lcd_rw,
  output logic          lcd_en,
  output logic [3:0]    lcd_d_out,
  output logic          lcd_d_oe,
  input  logic [3:0]    lcd_d_in
);
  logic [1:0] rsync_q;
  logic       rst_s_n;
  logic       start, st_rs, st_rw, cap, raw_o;
  logic [3:0] st_nib, cap_nib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  lcdb_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(bus_busy), .cap(cap), .cap_nib(cap_nib),
    .start(start), .st_rs(st_rs), .st_rw(st_rw), .st_nib(st_nib), .irq(irq),
    .raw_o(raw_o)
  );

  lcdb_phase #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_phase (
    .clk(clk), .rst_n(rst_s_n), .start(start), .st_rs(st_rs), .st_rw(st_rw),
    .st_nib(st_nib), .lcd_d_in(lcd_d_in), .busy(bus_busy), .cap(cap),
    .cap_nib(cap_nib), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
    .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe)
  );
endmodule

// File: rtl/lcdb_chk.sv
module lcdb_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          bus_busy,
  input logic          irq,
  input logic          raw_o,
  input logic          lcd_rs,
  input logic          lcd_rw,
  input logic          lcd_en,
  input logic [3:0]    lcd_d_out,
  input logic          lcd_d_oe
);
  logic touch_irq;
  assign touch_irq = wr_en && ((addr[AW-1:2] == 3'd3 && !wdata[8]) || addr[AW-1:2] == 3'd4);

  a_r4_en_in_busy: assert property (@(posedge clk) disable iff (!rst_s_n)
    lcd_en |-> bus_busy);
  a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rst_s_n)
    bus_busy && $past(bus_busy) |-> $stable(lcd_rs) && $stable(lcd_rw) && $stable(lcd_d_out));
  a_r5_setup_first: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(lcd_en) |-> $past(bus_busy));
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_s_n)
    lcd_rw |-> !lcd_d_oe);
  a_r7_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> raw_o);
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq && !touch_irq |=> irq);
endmodule

bind lcd_nib_bridge lcdb_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .bus_busy(bus_busy), .irq(irq), .raw_o(raw_o), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
  .lcd_en(lcd_en), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe)
);

// File: tb/tb_lcd_nib_bridge.sv
`timescale 1ns/1ps
module tb_lcd_nib_bridge;
  localparam int S = 2, P = 4, H = 2;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        bus_busy, irq, lcd_rs, lcd_rw, lcd_en, lcd_d_oe;
  logic [3:0]  lcd_d_out, lcd_d_in;
  int total = 0, bad = 0, pulses = 0;
  logic [5:0] expq[$];   // {is_read, rs, rw, check_nib(unused), nib} packed as {rd,rs,nib}

  always #2.5 clk = ~clk;

  lcd_nib_bridge #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bus_busy(bus_busy), .irq(irq),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en), .lcd_d_out(lcd_d_out),
    .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (bus_busy) @(negedge clk);
  endtask

  // expected item: bit5 = read, bit4 = rs, bits3:0 = nibble
  task automatic push(input logic rd, input logic rs, input logic [3:0] n);
    expq.push_back({rd, rs, n});
  endtask

  // monitor / scoreboard
  int bcnt = 0, ecnt = 0;
  logic en_prev = 1'b0, busy_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_en && !en_prev) begin
        pulses++;
        chk("R4 setup length", bcnt, S);
        if (expq.size() == 0) begin
          chk("R5 unexpected pulse", 1, 0);
        end else begin
          logic [5:0] e;
          e = expq.pop_front();
          chk(e[5] ? "R6 read rs/rw" : (e[4] ? "R3 data rs/rw" : "R2 cmd rs/rw"),
              {lcd_rs, lcd_rw}, {e[4], e[5]});
          if (!e[5]) chk("R2/R3 nibble and oe", {lcd_d_oe, lcd_d_out}, {1'b1, e[3:0]});
          else       chk("R6 oe low on read", lcd_d_oe, 1'b0);
        end
      end
      if (!lcd_en && en_prev) chk("R4 pulse width", ecnt, P);
      if (!bus_busy && busy_prev) chk("R4 busy length", bcnt, S + P + H);
      if (bus_busy) bcnt = bcnt + 1; else bcnt = 0;
      if (lcd_en) ecnt = ecnt + 1; else ecnt = 0;
      en_prev = lcd_en;
      busy_prev = bus_busy;
    end
  end

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; lcd_d_in = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 en/busy/irq", {lcd_en, bus_busy, irq}, 3'b000);
    bus_rd(5'h0C, d); chk("R1 raw", d, 32'h0);
    bus_rd(5'h10, d); chk("R1 mask", d, 32'h0);

    push(0, 0, 4'hA); bus_wr(5'h00, 32'h0000_00A5); wait_idle();
    push(0, 1, 4'h3); bus_wr(5'h04, 32'h0000_003C); wait_idle();
    push(0, 0, 4'hF); bus_wr(5'h00, 32'h0000_00F0); wait_idle();

    // R5: second access while busy is dropped
    push(0, 0, 4'h5); bus_wr(5'h00, 32'h50); bus_wr(5'h04, 32'h70); bus_rd(5'h00, d);
    wait_idle(); repeat (2) @(negedge clk);
    chk("R5 dropped accesses", pulses, 4);
    chk("R5 queue empty", expq.size(), 0);

    // R6/R7 first nibble with mask on
    bus_wr(5'h10, 32'h1);
    lcd_d_in = 4'h9; push(1, 0, 4'h0); bus_rd(5'h00, d); wait_idle();
    bus_rd(5'h0C, d); chk("R6 raw valid", d, 32'h100);
    chk("R7 irq", irq, 1'b1);
    bus_rd(5'h14, d); chk("R7 status", d, 32'h1);
    repeat (3) @(negedge clk); chk("R7 irq held", irq, 1'b1);
    bus_wr(5'h0C, 32'h0); chk("R7 irq cleared", irq, 1'b0);
    bus_rd(5'h0C, d); chk("R7 raw cleared", d, 32'h0);

    // R8 second nibble
    lcd_d_in = 4'h4; push(1, 0, 4'h0); bus_rd(5'h08, d); chk("R6 first nibble", d, 32'h90);
    wait_idle();
    bus_rd(5'h0C, d); chk("R8 raw set by second", d, 32'h100);
    chk("R8 no irq on second", irq, 1'b0);
    bus_rd(5'h08, d); chk("R8 second nibble", d, 32'h40);
    // R10 no pair open
    chk("R10 no cycle", bus_busy, 1'b0);
    repeat (2) @(negedge clk); chk("R10 pulses unchanged", pulses, 6);
    bus_wr(5'h0C, 32'h0);

    // R9 masked, late unmask
    bus_wr(5'h10, 32'h0);
    lcd_d_in = 4'hE; push(1, 0, 4'h0); bus_rd(5'h00, d); wait_idle();
    chk("R9 irq masked", irq, 1'b0);
    bus_rd(5'h14, d); chk("R9 status masked", d, 32'h0);
    bus_wr(5'h10, 32'h1); chk("R9 irq after unmask", irq, 1'b1);
    // R11 writing bit8=1 keeps flags
    bus_wr(5'h0C, 32'h100);
    chk("R11 irq kept", irq, 1'b1);
    bus_rd(5'h0C, d); chk("R11 raw kept", d, 32'h100);
    bus_wr(5'h0C, 32'h0); chk("R11 then cleared", irq, 1'b0);
    bus_rd(5'h08, d); chk("R6 nibble E", d, 32'hE0);
    push(1, 0, 4'h0); wait_idle();
    repeat (2) @(negedge clk);
    chk("R8 all cycles seen", expq.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule